// File: doc/BRIEF.md
# Stereo Soft-Ramped Attenuator

This block scales a stereo stream of 20-bit signed samples by a gain picked with a 6-bit attenuation code. The code selects a fixed-point gain from a table built at elaboration: 1 dB steps over most of the range, a few coarser steps near the bottom, and full cut for the highest codes. A mute input sets the target gain to zero. The gain is never switched in a single step. A ramp state machine moves the active gain toward its target by a fixed amount on each accepted sample, so that volume changes and mute do not produce clicks.

Samples arrive with a valid strobe at the sample rate. Each accepted pair produces one scaled pair, registered, one clock later. Both channels share one active gain. The volume code and the mute bit are registered on every clock. A code written while mute is on is therefore kept, and the ramp returns to it when mute is released.

The ramp state machine has three states. HOLD means the gain equals the target. FALL means the gain is above the target. RISE means the gain is below the target. On every clock the next state comes from comparing the gain with the target. HOLD goes to FALL or RISE when the target moves away. FALL and RISE go back to HOLD when the gain arrives. FALL goes directly to RISE, and RISE to FALL, when the target crosses to the other side of the gain part way through a ramp. The gain register steps only when a sample is accepted.

Top module: `stereo_vol_ramp`

## Requirements
- R1: While reset is asserted, and until the first sample is accepted after it, out_valid is 0 and both outputs are 0. The active gain leaves reset at zero, so the first sample after reset produces 0.
- R2: Gains are unsigned with 15 fraction bits (32768 = unity) and equal round(32768 * 10^(-A/20)), where A is the attenuation in dB. Codes 0 and 1 give A = 0. Codes 2 to 52 give A = code - 1: code 2 gives 29205, code 7 gives 16423 and code 52 gives 92.
- R3: Code 53 gives 52 dB (82), code 54 gives 54 dB (65), code 55 gives 57 dB (46) and code 56 gives 60 dB (33). Codes 57 to 63 give a gain of 0.
- R4: Each output equals floor((sample * gain + 16384) / 32768), clamped to the 20-bit signed range. It appears with out_valid one clock after in_valid. Without in_valid, out_valid is 0 and both outputs hold their last values.
- R5: The left and right channels are scaled by the same active gain.
- R6: On each accepted sample, the active gain moves toward the target by 32. It takes the target value exactly once the two are 32 or less apart. Without an accepted sample, the active gain does not change.
- R7: Mute makes the target zero. Starting from unity, the gain falls by 32 per sample: the 1024th sample after mute takes effect gives 32, and the 1025th gives 0.
- R8: A code changed while mute is on is stored. When mute is released, the gain ramps to that code's level.
- R9: If the target moves to the other side of the gain during a ramp, the next accepted sample moves the gain in the new direction.
- R10: Each output uses the gain held before its own sample. A code or mute change presented in the same clock as a sample steers the gain only from the following accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample pair strobe |
| in_left | input | 20 | Left sample, signed |
| in_right | input | 20 | Right sample, signed |
| vol_code | input | 6 | Attenuation code |
| mute | input | 1 | Soft mute request |
| out_valid | output | 1 | Scaled pair strobe |
| out_left | output | 20 | Scaled left sample, signed |
| out_right | output | 20 | Scaled right sample, signed |

## Verification
A setting change and a sample acceptance can fall in the same clock. In that case the gain step taken at that edge still aims at the old target, and the registered setting only steers the following samples. The bench provokes this by raising mute in the same clock that it presents a unity-level probe sample. It then expects two more full-scale outputs before the first reduced one. It also reverses the code part way through a fall and requires the next probe to rise by exactly one step.

// File: rtl/vol_pkg.sv
package vol_pkg;

    localparam int CODE_W    = 6;
    localparam int NCODES    = 1 << CODE_W;
    localparam int FINE_LAST = 52;

    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_FALL = 2'd1,
        RAMP_RISE = 2'd2
    } ramp_state_e;

    // attenuation in dB for a code, -1 meaning full cut
    function automatic int code_to_db(int c);
        if (c <= 1)
            return 0;
        else if (c <= FINE_LAST)
            return c - 1;
        else begin
            case (c)
                53:      return 52;
                54:      return 54;
                55:      return 57;
                56:      return 60;
                default: return -1;
            endcase
        end
    endfunction

    // unsigned fixed-point gain with frac_w fraction bits, rounded to nearest
    function automatic int db_to_gain(int db, int frac_w);
        real lin;
        if (db < 0)
            return 0;
        lin = $pow(2.0, frac_w) * $pow(10.0, -real'(db) / 20.0);
        return $rtoi(lin + 0.5);
    endfunction

endpackage

// File: rtl/vol_gain_rom.sv
module vol_gain_rom
    import vol_pkg::*;
#(
    parameter int GAIN_W = 16
) (
    input  logic [CODE_W-1:0] code,
    input  logic              mute,
    output logic [GAIN_W-1:0] target
);

    localparam int FRAC_W = GAIN_W - 1;
    localparam int TAB_W  = NCODES * GAIN_W;

    function automatic logic [TAB_W-1:0] build_tab();
        logic [TAB_W-1:0] t;
        t = '0;
        for (int c = 0; c < NCODES; c++)
            t[c*GAIN_W +: GAIN_W] = GAIN_W'(db_to_gain(code_to_db(c), FRAC_W));
        return t;
    endfunction

    localparam logic [TAB_W-1:0] GAIN_TAB = build_tab();

    always_comb begin
        if (mute)
            target = '0;
        else
            target = GAIN_TAB[int'(code)*GAIN_W +: GAIN_W];
    end

endmodule

// File: rtl/gain_ramper.sv
module gain_ramper
    import vol_pkg::*;
#(
    parameter int GAIN_W = 16,
    parameter int STEP   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [GAIN_W-1:0] target,
    output logic [GAIN_W-1:0] gain
);

    localparam logic [GAIN_W-1:0] STEP_V = GAIN_W'(STEP);

    ramp_state_e       state_q, state_d;
    logic [GAIN_W-1:0] gain_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= RAMP_HOLD;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RAMP_HOLD: begin
                if (target < gain_q)      state_d = RAMP_FALL;
                else if (target > gain_q) state_d = RAMP_RISE;
            end
            RAMP_FALL: begin
                if (target > gain_q)       state_d = RAMP_RISE;
                else if (target == gain_q) state_d = RAMP_HOLD;
            end
            RAMP_RISE: begin
                if (target < gain_q)       state_d = RAMP_FALL;
                else if (target == gain_q) state_d = RAMP_HOLD;
            end
            default: state_d = RAMP_HOLD;
        endcase
    end

    // output: gain steps once per accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n)
            gain_q <= '0;
        else if (advance) begin
            unique case (state_d)
                RAMP_FALL: gain_q <= (gain_q - target <= STEP_V) ? target : gain_q - STEP_V;
                RAMP_RISE: gain_q <= (target - gain_q <= STEP_V) ? target : gain_q + STEP_V;
                default:   gain_q <= gain_q;
            endcase
        end
    end

    assign gain = gain_q;

    // R6
    gain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(gain_q));

    // R6
    gain_slew_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (int'(gain_q) <= int'($past(gain_q)) + STEP) &&
                    (int'($past(gain_q)) <= int'(gain_q) + STEP));

    // R6
    gain_no_overshoot_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance && (gain_q <= target) |=> gain_q <= $past(target));

    // R6
    gain_no_overshoot_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance && (gain_q >= target) |=> gain_q >= $past(target));

    // R7
    gain_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance && (target == '0) && (gain_q != '0) |=> gain_q < $past(gain_q));

endmodule

// File: rtl/chan_scaler.sv
module chan_scaler #(
    parameter int SAMP_W = 20,
    parameter int GAIN_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [SAMP_W-1:0] sample,
    input  logic        [GAIN_W-1:0] gain,
    output logic signed [SAMP_W-1:0] scaled
);

    localparam int FRAC_W = GAIN_W - 1;
    localparam int PROD_W = SAMP_W + GAIN_W + 1;
    localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((longint'(1) << (SAMP_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] SAT_LO = -SAT_HI - PROD_W'(1);
    localparam logic signed [PROD_W-1:0] HALF   = PROD_W'(longint'(1) << (FRAC_W - 1));

    logic signed [PROD_W-1:0] a_ext, b_ext, prod, rounded, shifted;
    logic signed [SAMP_W-1:0] clamped;

    always_comb begin
        a_ext   = PROD_W'(sample);
        b_ext   = PROD_W'($signed({1'b0, gain}));
        prod    = a_ext * b_ext;
        rounded = prod + HALF;
        shifted = rounded >>> FRAC_W;
        if (shifted > SAT_HI)
            clamped = SAT_HI[SAMP_W-1:0];
        else if (shifted < SAT_LO)
            clamped = SAT_LO[SAMP_W-1:0];
        else
            clamped = shifted[SAMP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            scaled <= '0;
        else if (in_valid)
            scaled <= clamped;
    end

    // R7
    zero_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (gain == '0) |=> scaled == '0);

    // R4
    unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (gain == GAIN_W'(longint'(1) << FRAC_W)) |=> scaled == $past(sample));

endmodule

// File: rtl/stereo_vol_ramp.sv
module stereo_vol_ramp
    import vol_pkg::*;
#(
    parameter int SAMP_W    = 20,
    parameter int GAIN_W    = 16,
    parameter int RAMP_STEP = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [SAMP_W-1:0] in_left,
    input  logic signed [SAMP_W-1:0] in_right,
    input  logic        [CODE_W-1:0] vol_code,
    input  logic                     mute,
    output logic                     out_valid,
    output logic signed [SAMP_W-1:0] out_left,
    output logic signed [SAMP_W-1:0] out_right
);

    localparam int NCH = 2;

    logic [CODE_W-1:0] code_q;
    logic              mute_q;
    logic [GAIN_W-1:0] target;
    logic [GAIN_W-1:0] gain;
    logic signed [SAMP_W-1:0] ch_in  [NCH];
    logic signed [SAMP_W-1:0] ch_out [NCH];

    // settings are kept every clock, also while muted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            mute_q <= 1'b0;
        end else begin
            code_q <= vol_code;
            mute_q <= mute;
        end
    end

    vol_gain_rom #(.GAIN_W(GAIN_W)) u_rom (
        .code   (code_q),
        .mute   (mute_q),
        .target (target)
    );

    gain_ramper #(.GAIN_W(GAIN_W), .STEP(RAMP_STEP)) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (in_valid),
        .target  (target),
        .gain    (gain)
    );

    assign ch_in[0] = in_left;
    assign ch_in[1] = in_right;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        chan_scaler #(.SAMP_W(SAMP_W), .GAIN_W(GAIN_W)) u_scl (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid),
            .sample   (ch_in[i]),
            .gain     (gain),
            .scaled   (ch_out[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    assign out_left  = ch_out[0];
    assign out_right = ch_out[1];

    // R4
    out_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_left) && $stable(out_right));

    // R5
    twin_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_left == in_right) |=> out_left == out_right);

    // R8
    mute_hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute_q && mute |=> mute_q && (code_q == $past(vol_code)));

endmodule

// File: tb/stereo_vol_ramp_bench.sv
module stereo_vol_ramp_bench;

    localparam int SW = 20;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                 rst_n;
    logic                 in_valid;
    logic signed [SW-1:0] in_left, in_right;
    logic [5:0]           vol_code;
    logic                 mute;
    logic                 out_valid;
    logic signed [SW-1:0] out_left, out_right;

    int     n_chk = 0;
    int     n_fail = 0;
    int     g_m = 0;
    int     tgt_m = 0;
    longint last_l = 0;
    longint last_r = 0;

    stereo_vol_ramp u_stereo_vol_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_left   (in_left),
        .in_right  (in_right),
        .vol_code  (vol_code),
        .mute      (mute),
        .out_valid (out_valid),
        .out_left  (out_left),
        .out_right (out_right)
    );

    // R2 R3 gain for a code
    function automatic int ref_gain(int c, bit m);
        int  db;
        real x;
        if (m) return 0;
        if (c <= 1)       db = 0;
        else if (c <= 52) db = c - 1;
        else if (c == 53) db = 52;
        else if (c == 54) db = 54;
        else if (c == 55) db = 57;
        else if (c == 56) db = 60;
        else return 0;
        x = 32768.0 * $pow(10.0, -real'(db) / 20.0);
        return $rtoi(x + 0.5);
    endfunction

    // R4 scaling
    function automatic longint ref_scale(longint s, longint g);
        longint p;
        p = (s * g + 16384) >>> 15;
        if (p > 524287)  p = 524287;
        if (p < -524288) p = -524288;
        return p;
    endfunction

    // R6 slew
    function automatic int ref_move(int g, int t);
        if (g < t) return (t - g <= 32) ? t : g + 32;
        if (g > t) return (g - t <= 32) ? t : g - 32;
        return g;
    endfunction

    task automatic check(string req, string what, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // one clock: drive at negedge, model at the coming edge, compare at next negedge
    task automatic cyc(bit v, int l, int r, string req);
        longint el, er;
        in_valid = v;
        in_left  = SW'(l);
        in_right = SW'(r);
        if (v) begin
            el  = ref_scale(l, g_m);
            er  = ref_scale(r, g_m);
            g_m = ref_move(g_m, tgt_m);
        end else begin
            el = last_l;
            er = last_r;
        end
        tgt_m = ref_gain(int'(vol_code), mute);
        @(posedge clk);
        @(negedge clk);
        check(req, "valid", longint'(out_valid), longint'(v));
        check(req, "left",  longint'(out_left),  el);
        check(req, "right", longint'(out_right), er);
        last_l = el;
        last_r = er;
    endtask

    task automatic probe(string req);
        cyc(1'b1, 32768, 32768, req);
    endtask

    task automatic set_cfg(int c, bit m, string req);
        vol_code = 6'(c);
        mute     = m;
        cyc(1'b0, 0, 0, req);
    endtask

    task automatic settle(string req);
        repeat (1030) probe(req);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b0; in_left = '0; in_right = '0;
        vol_code = '0; mute = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", longint'(out_valid), 0);
        check("R1", "left in reset", longint'(out_left), 0);
        check("R1", "right in reset", longint'(out_right), 0);
        rst_n = 1'b1;
        g_m = 0; tgt_m = ref_gain(0, 1'b0); last_l = 0; last_r = 0;
        probe("R1");
        check("R1", "first sample after reset", last_l, 0);
    endtask

    task automatic t_table;
        int codes [11] = '{0, 1, 2, 7, 52, 53, 54, 55, 56, 57, 63};
        int lits  [11] = '{32768, 32768, 29205, 16423, 92, 82, 65, 46, 33, 0, 0};
        foreach (codes[i]) begin
            set_cfg(codes[i], 1'b0, codes[i] > 52 ? "R3" : "R2");
            settle(codes[i] > 52 ? "R3" : "R2");
            check(codes[i] > 52 ? "R3" : "R2", $sformatf("gain code %0d", codes[i]), last_l, lits[i]);
        end
        set_cfg(0, 1'b0, "R2");
        settle("R2");
        check("R2", "back to unity", last_l, 32768);
    endtask

    task automatic t_scale;
        int pats [6] = '{524287, -524288, -1, 1, -3, 12345};
        foreach (pats[i]) cyc(1'b1, pats[i], pats[i], "R4");
        check("R4", "unity keeps sample", last_l, 12345);
        set_cfg(7, 1'b0, "R4");
        settle("R4");
        foreach (pats[i]) cyc(1'b1, pats[i], -pats[i] - 1, "R4");
        repeat (3) cyc(1'b0, 777, 777, "R4");
        probe("R6");
        check("R6", "gain frozen while idle", last_l, 16423);
    endtask

    task automatic t_stereo;
        cyc(1'b1, 100000, -200000, "R5");
        cyc(1'b1, -524288, 524287, "R5");
        check("R5", "right uses shared gain", last_r, ref_scale(524287, 16423));
    endtask

    task automatic t_mute;
        set_cfg(0, 1'b0, "R7");
        settle("R7");
        set_cfg(0, 1'b1, "R7");
        repeat (1023) probe("R7");
        probe("R7");
        check("R7", "sample 1024 still soft", last_l, 32);
        probe("R7");
        check("R7", "sample 1025 silent", last_l, 0);
    endtask

    task automatic t_store;
        set_cfg(21, 1'b1, "R8");
        repeat (5) probe("R8");
        check("R8", "muted output", last_l, 0);
        set_cfg(21, 1'b0, "R8");
        settle("R8");
        check("R8", "stored level after unmute", last_l, 3277);
    endtask

    task automatic t_reverse;
        longint a;
        set_cfg(0, 1'b0, "R9");
        settle("R9");
        set_cfg(41, 1'b0, "R9");
        repeat (10) probe("R9");
        set_cfg(0, 1'b0, "R9");
        probe("R9");
        a = last_l;
        check("R9", "gain after partial fall", a, 32448);
        probe("R9");
        check("R9", "rise after reversal", last_l - a, 32);
    endtask

    task automatic t_collide;
        set_cfg(0, 1'b0, "R10");
        settle("R10");
        mute = 1'b1;
        probe("R10");
        check("R10", "sample with mute edge", last_l, 32768);
        probe("R10");
        check("R10", "next sample still unity", last_l, 32768);
        probe("R10");
        check("R10", "fall starts", last_l, 32736);
        mute = 1'b0;
        settle("R10");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_table();
        t_scale();
        t_stereo();
        t_mute();
        t_store();
        t_reverse();
        t_collide();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule